// File: doc/BRIEF.md
# Queued Command SPI Master

This block is an SPI master that works through a queue of up to sixteen transfer entries without processor help. Each queue slot pairs a command word with two transmit byte slots and two receive byte slots. The command word chooses the chip-select line, whether chip select stays low after the entry, whether the entry moves one byte or two, and whether the entry uses one lane or four.

Software sets up the queue through a small word-addressed register port. It loads the command and transmit slots, writes the first and last queue indices, clears the status word, and then sets the run bit. The engine shifts each entry in turn and writes what it captures into the receive slots. When the last entry finishes it sets a done flag. The serial clock rate comes from a programmable divider, and the clock polarity and phase are chosen by mode bits.

Top module: `qspi_queue_master`

## Requirements
- R1: After reset all chip-select outputs are high, `sck` is low, `io_oe` is 0 and status (address 0x05) reads 0.
- R2: A write to the control word (0x04) with bit 6 set starts a run, but only while the mode word has its master bit set and no run is active. The run covers the queue from the first index (0x02) to the last index (0x03) inclusive, counting modulo 16. Status bit 0 goes to 1 when the last entry ends. Any write to 0x05 clears it. Reading control bit 6 shows whether a run is active.
- R3: While mode (0x01) bit 7 is 0, a start write is ignored: chip select stays high and status stays 0.
- R4: Each `sck` half-period lasts D system clocks. D is the divider (0x00, 8 bits), or 8 when the divider is below 8.
- R5: Mode bit 1 is the idle level of `sck`. With mode bit 0 clear, data is captured on the leading edge and changes on the trailing edge. With mode bit 0 set, data changes on the leading edge of every bit but the first and is captured on the trailing edge.
- R6: The command word of entry n is at 0x20+n. Bits 1:0 give the chip-select index, bit 6 selects 16-bit grouping, bit 7 is continue, bit 8 selects quad lanes and bit 10 (with bit 8) makes the entry input-only. At most one chip select is low at a time.
- R7: Entry n transmits byte 0x40+2n, followed by 0x40+2n+1 in 16-bit mode, MSB first. Received bytes go to 0x60+2n (and 0x60+2n+1). In single-lane mode the data leaves on lane 0 with only lane 0 enabled, and arrives on lane 1.
- R8: A quad entry moves 4 bits per `sck` period on lanes 3:0, with lane 3 carrying the most significant bit, and all four lanes enabled. In an input-only entry all lanes are released.
- R9: Between two entries, chip select stays low if the earlier entry has its continue bit set. Otherwise chip select goes high for D clocks.
- R10: When a run ends, chip select stays low if control bit 7 was set at start or the last entry has its continue bit set. Otherwise it goes high. `sck` returns to idle and all lanes are released.
- R11: Writing control with bit 6 clear stops a run at once and releases chip select. Done is not set.
- R12: While a run is active, writes to command slots, transmit slots and the two queue indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 7 | register word address |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | register read data (combinational) |
| sck | output | 1 | serial clock |
| cs_n | output | 4 | active-low chip selects |
| io_out | output | 4 | lane output values |
| io_oe | output | 4 | lane output enables |
| io_in | input | 4 | lane input values |

## Verification
The divider count, the half-phase bit or the step counter can go wrong. If they do, `sck` edges move or an extra bit is shifted, and the pins diverge from the model within one half-period. A wrong queue pointer or a wrong latch of the continue bit shows up as a chip-select glitch or a missing gap at the next entry boundary. A fault in the receive path is invisible at the pins and only appears when the receive slots are read back after the run. For this reason every run ends with readback of every slot it filled.

// File: rtl/qspi_queue_master.sv
module qspi_queue_master #(
  parameter int NCS     = 4,
  parameter int MIN_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        sck,
  output logic [NCS-1:0] cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int NQ = 16;
  localparam int QW = $clog2(NQ);
  localparam int CW = $clog2(NCS);
  localparam logic [6:0] A_DIV = 7'h00, A_MODE = 7'h01, A_SPTR = 7'h02,
                         A_EPTR = 7'h03, A_CTRL = 7'h04, A_STAT = 7'h05;

  logic [7:0]    div_r, mode_r, cnt;
  logic [QW-1:0] sptr, eptr, q;
  logic          cc_r, run, gap, hold, done, h;
  logic [4:0]    step;
  logic [15:0]   sreg, rxs;
  logic [CW-1:0] sel;
  logic [10:0]   cmd_m [NQ];
  logic [7:0]    tx_m  [2*NQ];
  logic [7:0]    rx_m  [2*NQ];

  function automatic logic [15:0] shin(input logic [15:0] v, input logic [3:0] b, input logic qd);
    return qd ? {v[11:0], b} : {v[14:0], b[0]};
  endfunction

  wire [10:0] cur    = cmd_m[q];
  wire        wide   = cur[6];
  wire        cont   = cur[7];
  wire        quad   = cur[8];
  wire        inonly = cur[8] & cur[10];
  wire        cpol   = mode_r[1];
  wire        cpha   = mode_r[0];
  wire [7:0]  div_e  = (div_r < 8'(MIN_DIV)) ? 8'(MIN_DIV) : div_r;
  wire        tick   = (cnt == div_e - 8'd1);
  wire [4:0]  nsteps = quad ? (wide ? 5'd4 : 5'd2) : (wide ? 5'd16 : 5'd8);
  wire        active = run && !gap;
  wire [3:0]  smp    = quad ? io_in : {3'b000, io_in[1]};
  wire [15:0] rx_fin = cpha ? shin(rxs, smp, quad) : rxs;
  wire        ctl_wr = reg_we && (reg_addr == A_CTRL);
  wire        start  = ctl_wr && reg_wdata[6] && mode_r[7] && !run;
  wire        stop   = ctl_wr && !reg_wdata[6];
  wire        ent_end = active && tick && h && (step == nsteps - 5'd1);

  wire [QW-1:0] ld_q   = run ? q + 1'b1 : sptr;
  wire [10:0]   ld_cmd = cmd_m[ld_q];
  wire [15:0]   ld_tx  = ld_cmd[6] ? {tx_m[{ld_q, 1'b0}], tx_m[{ld_q, 1'b1}]}
                                   : {tx_m[{ld_q, 1'b0}], 8'h00};

  always_ff @(posedge clk) begin
    if (reg_we && !run) begin
      if (reg_addr[6:4] == 3'b010) cmd_m[reg_addr[QW-1:0]] <= reg_wdata[10:0];
      if (reg_addr[6:5] == 2'b10)  tx_m[reg_addr[4:0]]     <= reg_wdata[7:0];
    end
    if (ent_end) begin
      if (wide) begin
        rx_m[{q, 1'b0}] <= rx_fin[15:8];
        rx_m[{q, 1'b1}] <= rx_fin[7:0];
      end else begin
        rx_m[{q, 1'b0}] <= rx_fin[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_r <= '0; mode_r <= '0; sptr <= '0; eptr <= '0; q <= '0; sel <= '0;
      cc_r <= 1'b0; run <= 1'b0; gap <= 1'b0; hold <= 1'b0; done <= 1'b0; h <= 1'b0;
      cnt <= '0; step <= '0; sreg <= '0; rxs <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_DIV:  div_r <= reg_wdata[7:0];
          A_MODE: mode_r <= reg_wdata[7:0];
          A_SPTR: if (!run) sptr <= reg_wdata[QW-1:0];
          A_EPTR: if (!run) eptr <= reg_wdata[QW-1:0];
          A_STAT: done <= 1'b0;
          default: ;
        endcase
      end
      if (stop) begin
        run <= 1'b0; gap <= 1'b0; hold <= 1'b0;
      end else if (start) begin
        run <= 1'b1; hold <= 1'b0; gap <= 1'b0; cc_r <= reg_wdata[7];
        q <= ld_q; sel <= ld_cmd[CW-1:0]; sreg <= ld_tx; rxs <= '0;
        cnt <= '0; h <= 1'b0; step <= '0;
      end else if (run) begin
        cnt <= tick ? 8'd0 : cnt + 8'd1;
        if (gap) begin
          if (tick) gap <= 1'b0;
        end else if (tick) begin
          h <= !h;
          if (!h) begin
            if (cpha) begin
              if (step != 5'd0) sreg <= quad ? sreg << 4 : sreg << 1;
            end else rxs <= shin(rxs, smp, quad);
          end else begin
            if (cpha) rxs <= shin(rxs, smp, quad);
            else sreg <= quad ? sreg << 4 : sreg << 1;
            step <= step + 5'd1;
            if (ent_end) begin
              step <= '0;
              if (q == eptr) begin
                run <= 1'b0; done <= 1'b1; hold <= cc_r | cont;
              end else begin
                q <= ld_q; sel <= ld_cmd[CW-1:0]; sreg <= ld_tx; rxs <= '0; gap <= !cont;
              end
            end
          end
        end
      end
    end
  end

  assign sck    = cpol ^ (active && h);
  assign io_oe  = !active ? 4'h0 : quad ? (inonly ? 4'h0 : 4'hF) : 4'h1;
  assign io_out = quad ? sreg[15:12] : {3'b000, sreg[15]};

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !((active || hold) && sel == CW'(i));
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DIV:  reg_rdata = {8'h00, div_r};
      A_MODE: reg_rdata = {8'h00, mode_r};
      A_SPTR: reg_rdata = 16'(sptr);
      A_EPTR: reg_rdata = 16'(eptr);
      A_CTRL: reg_rdata = {8'h00, cc_r, run, 6'b000000};
      A_STAT: reg_rdata = {15'h0000, done};
      default: begin
        if (reg_addr[6:4] == 3'b010) reg_rdata = {5'b00000, cmd_m[reg_addr[QW-1:0]]};
        else if (reg_addr[6:5] == 2'b10) reg_rdata = {8'h00, tx_m[reg_addr[4:0]]};
        else if (reg_addr[6:5] == 2'b11) reg_rdata = {8'h00, rx_m[reg_addr[4:0]]};
      end
    endcase
  end

  a_r6_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r2_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(run));
  a_r4_sck_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick) && $stable(mode_r)) |-> $stable(sck));
  a_r10_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (io_oe == 4'h0));
  a_r11_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!run && cs_n == '1));
  a_r12_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(eptr) && $stable(sptr)));
endmodule

// File: tb/test_qspi_queue_master.sv
module test_qspi_queue_master;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic sck;
  logic [3:0] cs_n, io_out, io_oe, io_in = '0;

  qspi_queue_master i_qspi_queue_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  always #4 clk = ~clk;

  int ncmp = 0, nerr = 0, cyc_g = 0, d_b = 8;
  bit cpol_b = 0, cpha_b = 0, poke_g = 0;
  logic [10:0] cmd_b [16];
  logic [7:0]  tx_b [32];
  logic [7:0]  sl_b [32];
  logic [7:0]  rx_b [32];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
  endtask

  task automatic chk(input string tag, input logic [3:0] cs_e, input logic sck_e,
                     input logic [3:0] oe_e, input logic [3:0] out_e);
    ncmp++;
    if (cs_n !== cs_e || sck !== sck_e || io_oe !== oe_e || (io_out & io_oe) !== (out_e & oe_e)) begin
      nerr++;
      $display("FAIL %s t=%0t cs_n/sck/oe/out act %h/%b/%h/%h exp %h/%b/%h/%h", tag, $time,
               cs_n, sck, io_oe, io_out & io_oe, cs_e, sck_e, oe_e, out_e & oe_e);
    end
  endtask

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pace();
    if (poke_g) begin
      case (cyc_g)
        3: begin reg_we = 1'b1; reg_addr = 7'h03; reg_wdata = 16'h000F; end
        4: begin reg_addr = 7'h20; reg_wdata = 16'h0100; end
        5: begin reg_addr = 7'h40; reg_wdata = 16'h00EE; end
        6: reg_we = 1'b0;
        default: ;
      endcase
    end
    cyc_g++;
    @(negedge clk);
  endtask

  task automatic set_cmd(input int n, input logic [10:0] v);
    cmd_b[n] = v; wr(7'(32 + n), 16'(v));
  endtask

  task automatic set_tx(input int n, input logic [7:0] v);
    tx_b[n] = v; wr(7'(64 + n), 16'(v));
  endtask

  task automatic run_model(input int s, input int e, input bit cc);
    logic [10:0] c;
    logic [15:0] t16, s16;
    logic [3:0] oe, out;
    int n, ns, j;
    bit qd, wd, gap_b;
    n = s; gap_b = 0; cyc_g = 0;
    forever begin
      c = cmd_b[n]; wd = c[6]; qd = c[8];
      ns = qd ? (wd ? 4 : 2) : (wd ? 16 : 8);
      t16 = wd ? {tx_b[2*n], tx_b[2*n+1]} : {tx_b[2*n], 8'h00};
      s16 = wd ? {sl_b[2*n], sl_b[2*n+1]} : {sl_b[2*n], 8'h00};
      oe  = qd ? ((c[8] && c[10]) ? 4'h0 : 4'hF) : 4'h1;
      if (gap_b) begin
        io_in = '0;
        for (int i = 0; i < d_b; i++) begin chk("R9 gap", 4'hF, cpol_b, 4'h0, 4'h0); pace(); end
      end
      for (int k = 0; k < ns; k++) begin
        io_in = qd ? 4'((s16 >> (12 - 4*k)) & 16'hF) : {2'b00, s16[15-k], 1'b0};
        for (int hh = 0; hh < 2; hh++) begin
          for (int i = 0; i < d_b; i++) begin
            j = (cpha_b && hh == 0 && k > 0) ? k - 1 : k;
            out = qd ? 4'((t16 >> (12 - 4*j)) & 16'hF) : {3'b000, t16[15-j]};
            chk(qd ? "R8 R4/R5 quad" : "R7 R4/R5 single", ~(4'b0001 << c[1:0]),
                cpol_b ^ hh[0], oe, out);
            pace();
          end
        end
      end
      rx_b[2*n] = s16[15:8];
      if (wd) rx_b[2*n+1] = s16[7:0];
      if (n == e) break;
      gap_b = !c[7];
      n = (n + 1) % 16;
    end
    io_in = '0;
    chk("R10 end", (cc || cmd_b[e][7]) ? ~(4'b0001 << cmd_b[e][1:0]) : 4'hF, cpol_b, 4'h0, 4'h0);
  endtask

  task automatic check_rx(input int lo, input int hi);
    logic [15:0] v;
    for (int i = lo; i <= hi; i++) begin
      rd(7'(96 + i), v);
      cmp("R7 rx slot", v, 16'(rx_b[i]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act running exp finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", 4'hF, 1'b0, 4'h0, 4'h0);
    rd(7'h05, v); cmp("R1 status", v, 16'h0000);

    // R4 clamp, R5 mode 0, R7 single 8-bit, R9 continue
    wr(7'h00, 16'h0003); d_b = 8;
    wr(7'h01, 16'h0080); cpol_b = 0; cpha_b = 0;
    set_cmd(0, 11'h081); set_cmd(1, 11'h001);
    set_tx(0, 8'hA5); set_tx(2, 8'h3C);
    sl_b[0] = 8'h5A; sl_b[2] = 8'hC3;
    wr(7'h02, 16'h0000); wr(7'h03, 16'h0001); wr(7'h05, 16'h0000);
    wr(7'h04, 16'h0040);
    run_model(0, 1, 0);
    check_rx(0, 0); check_rx(2, 2);
    rd(7'h05, v); cmp("R2 done set", v, 16'h0001);
    wr(7'h05, 16'h0000);
    rd(7'h05, v); cmp("R2 done clear", v, 16'h0000);

    // R5 cpol1 cpha1, R7 16-bit, R9 gap, R10 hold via control bit 7
    wr(7'h00, 16'h000A); d_b = 10;
    wr(7'h01, 16'h0083); cpol_b = 1; cpha_b = 1;
    set_cmd(2, 11'h042); set_cmd(3, 11'h042);
    set_tx(4, 8'h12); set_tx(5, 8'h34); set_tx(6, 8'hF0); set_tx(7, 8'h0F);
    sl_b[4] = 8'h9C; sl_b[5] = 8'h63; sl_b[6] = 8'h81; sl_b[7] = 8'h7E;
    wr(7'h02, 16'h0002); wr(7'h03, 16'h0003);
    wr(7'h04, 16'h00C0);
    run_model(2, 3, 1);
    check_rx(4, 7);
    chk("R10 hold persists", 4'b1011, 1'b1, 4'h0, 4'h0);

    // R8 quad out 16-bit then quad input-only 8-bit
    wr(7'h00, 16'h0008); d_b = 8;
    wr(7'h01, 16'h0080); cpol_b = 0; cpha_b = 0;
    set_cmd(4, 11'h1C0); set_cmd(5, 11'h500);
    set_tx(8, 8'hB7); set_tx(9, 8'h4E); set_tx(10, 8'hFF);
    sl_b[8] = 8'h2D; sl_b[9] = 8'hE1; sl_b[10] = 8'h96;
    wr(7'h02, 16'h0004); wr(7'h03, 16'h0005); wr(7'h05, 16'h0000);
    wr(7'h04, 16'h0040);
    run_model(4, 5, 0);
    check_rx(8, 10);
    rd(7'h05, v); cmp("R2 done quad", v, 16'h0001);

    // R2 wrap 15->0, R12 writes ignored mid-run
    wr(7'h01, 16'h0081); cpol_b = 0; cpha_b = 1;
    set_cmd(15, 11'h083); set_cmd(0, 11'h003);
    set_tx(30, 8'hC9); set_tx(0, 8'h81);
    sl_b[30] = 8'h35; sl_b[0] = 8'h7E;
    wr(7'h02, 16'h000F); wr(7'h03, 16'h0000); wr(7'h05, 16'h0000);
    poke_g = 1;
    wr(7'h04, 16'h0040);
    run_model(15, 0, 0);
    poke_g = 0;
    check_rx(30, 30); check_rx(0, 0);
    rd(7'h40, v); cmp("R12 tx slot kept", v, 16'h0081);
    rd(7'h20, v); cmp("R12 cmd slot kept", v, 16'h0003);
    rd(7'h03, v); cmp("R12 end index kept", v, 16'h0000);

    // R11 stop mid-run
    wr(7'h02, 16'h0000); wr(7'h03, 16'h0001); wr(7'h05, 16'h0000);
    wr(7'h04, 16'h0040);
    rd(7'h04, v); cmp("R2 run visible", v & 16'h0040, 16'h0040);
    repeat (20) @(negedge clk);
    wr(7'h04, 16'h0000);
    chk("R11 stop pins", 4'hF, 1'b0, 4'h0, 4'h0);
    rd(7'h05, v); cmp("R11 no done", v, 16'h0000);
    rd(7'h04, v); cmp("R11 run clear", v & 16'h0040, 16'h0000);

    // R3 start ignored without master bit
    wr(7'h01, 16'h0000);
    wr(7'h04, 16'h0040);
    for (int i = 0; i < 40; i++) begin
      chk("R3 no run", 4'hF, 1'b0, 4'h0, 4'h0);
      @(negedge clk);
    end
    rd(7'h05, v); cmp("R3 status", v, 16'h0000);
    rd(7'h04, v); cmp("R3 run bit", v & 16'h0040, 16'h0000);

    summary();
    $finish;
  end
endmodule